// File: doc/BRIEF.md
# Management Register Bank with Latching Status Bits

This block sits behind a management-interface front end that has already removed the serial framing. For each access the front end presents a port address, a device designation, a 16-bit register address, 16-bit write data, and a single-cycle read or write strobe. The bank accepts an access only when the port address matches a fixed value. The device designation selects the register space: device 0 holds chip-wide registers, and devices 1 to 3 each hold an identical per-lane register set. Registers are 8 bits wide. A 16-bit access is well formed only when its upper byte is zero.

Each register is one of five kinds:

- read/write
- read-only
- latching-low status
- latching-high status
- self-clearing command

A latching bit captures a transient event on a live status input and holds it until software reads the register. After that read it follows the live input again. A command bit that software sets drives a request output to the monitored logic, and it clears when that logic returns a done pulse. The access port has no back-pressure: every strobe is taken in the cycle it is presented. A read answers exactly one cycle later on `rd_valid_o`/`rd_data_o`, and the consumer must take that answer in that cycle.

Register map:

- Chip space: 0x00 config (read/write), 0x01 identifier (read-only), 0x02 alarm (latching-high, bits 3:0), 0x03 divider (read/write, bits 4:0), 0x04 command (self-clearing, bits 1:0).
- Lane space: 0x00 config (read/write), 0x01 link status (latching-low, bits 3:0), 0x02 error (latching-high, bits 3:0), 0x03 command (self-clearing, bit 0).

Top module: `mgmt_reg_bank`

## Requirements
- R1: An access whose port address differs from PORT_ADDR (default 0) is ignored. It writes nothing, produces no `rd_valid_o` and does not release any latched bit.
- R2: Device 0 selects the chip space and devices 1, 2 and 3 select lanes 0, 1 and 2. Writes to any other device have no effect, and reads of any other device return 0x0000.
- R3: An access with a nonzero address upper byte is unmapped: its write is dropped and its read returns 0x0000. A write whose data upper byte is nonzero is dropped. Read data always has upper byte 0.
- R4: A read strobe in cycle N makes `rd_valid_o` high and `rd_data_o` valid in cycle N+1. `rd_valid_o` is high for that one cycle only.
- R5: The chip config register (0x00) and each lane config register (0x00) store all 8 written bits. They drive `gen_cfg_o` and lane l's byte of `lane_cfg_o` from the cycle after the write.
- R6: The chip divider register (0x03) is 5 bits wide. A write keeps data bits 4:0 and forces the bits above them to 0, and `gen_div_o` shows the stored value. A read returns the stored value in bits 4:0; bits 7:5 of the read are unspecified.
- R7: The chip identifier register (0x01) reads CHIP_ID (default 0x5C), and writes to it have no effect.
- R8: Each lane link bit (lane 0x01, bit b = `lane_link_i[l*4+b]`) is latching-low. Once its input is low at a clock edge, the bit reads 0 until that register is read, even if the input returns high.
- R9: After a read releases a latched bit, the bit again shows the live input. A read always returns the held event value.
- R10: Each lane error bit (lane 0x02, bit b = `lane_err_i[l*4+b]`) and each chip alarm bit (chip 0x02, bit b = `gen_alarm_i[b]`) is latching-high. A high input at a clock edge reads as 1 until the register is read.
- R11: If the input event occurs in the same cycle as the read that releases the latch, the bit stays latched and the following read still shows the event.
- R12: Writing 1 to a command bit (chip 0x04 bits 1:0, lane 0x03 bit 0) sets it and its request output (`gen_cmd_o`, bit l of `lane_cmd_o`) from the next cycle. The bit stays set until its done input is high at a clock edge, then clears. Writing 0 has no effect, and a read shows the bit.
- R13: Writes to read-only or latching registers have no effect, and reads of unmapped offsets return 0x0000.
- R14: After reset, all read/write and command registers are 0, no event is latched, and `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_port_i | input | PORT_W | Port address of the access |
| acc_dev_i | input | DEV_W | Device designation |
| acc_addr_i | input | 16 | Register address |
| acc_wdata_i | input | 16 | Write data |
| acc_rd_i | input | 1 | Read strobe |
| acc_wr_i | input | 1 | Write strobe |
| rd_valid_o | output | 1 | Read answer valid, one cycle after the strobe |
| rd_data_o | output | 16 | Read answer |
| gen_alarm_i | input | ALM_W | Live chip alarm conditions |
| gen_done_i | input | CMD_W | Completion for chip command bits |
| gen_cfg_o | output | 8 | Chip config register |
| gen_div_o | output | DIV_W | Chip divider field |
| gen_cmd_o | output | CMD_W | Chip command requests |
| lane_link_i | input | NLANE*LINK_W | Live link conditions, lane-major |
| lane_err_i | input | NLANE*ERR_W | Live error conditions, lane-major |
| lane_done_i | input | NLANE | Completion for each lane command bit |
| lane_cfg_o | output | NLANE*8 | Lane config registers, lane-major |
| lane_cmd_o | output | NLANE | Lane command requests |

## Verification
The hardest case to reach is the collision in which a live condition drops in exactly the cycle the releasing read is presented. It can only be seen through a second read. The stimulus first latches an event on one link bit and lets the input recover. It then drives the input low again at the same falling edge at which it raises the read strobe. After that it reads twice: the first read shows the event still held, and the second shows the recovered live value. A port-filtered read is also placed against a held event, to show that a foreign access cannot release it.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int REG_W = 8;

  // chip space offsets
  localparam logic [7:0] G_CFG   = 8'h00;
  localparam logic [7:0] G_ID    = 8'h01;
  localparam logic [7:0] G_ALARM = 8'h02;
  localparam logic [7:0] G_DIV   = 8'h03;
  localparam logic [7:0] G_CMD   = 8'h04;

  // lane space offsets
  localparam logic [7:0] L_CFG   = 8'h00;
  localparam logic [7:0] L_LINK  = 8'h01;
  localparam logic [7:0] L_ERR   = 8'h02;
  localparam logic [7:0] L_CMD   = 8'h03;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [REG_W-1:0] addr;
    logic [REG_W-1:0] wdata;
  } reg_req_t;
endpackage

// File: rtl/mrb_latch_bank.sv
module mrb_latch_bank #(
  parameter int W         = 4,
  parameter bit HOLD_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_i,
  input  logic         release_i,
  output logic [W-1:0] shown_o
);
  logic [W-1:0] act;
  logic [W-1:0] hold_q;
  logic [W-1:0] show_act;

  // normalise polarity so the holding logic is shared
  generate
    if (HOLD_HIGH) begin : g_high
      assign act     = live_i;
      assign shown_o = show_act;
    end else begin : g_low
      assign act     = ~live_i;
      assign shown_o = ~show_act;
    end
  endgenerate

  assign show_act = act | hold_q;

  // a fresh event outranks the release issued by a read
  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= act | (hold_q & {W{~release_i}});
  end

  a_r8_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    !release_i |=> ((hold_q & $past(hold_q)) == $past(hold_q)));
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> ((hold_q & $past(act)) == $past(act)));
  a_r9_release_follows_live: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> ((hold_q & ~$past(act)) == '0));
endmodule

// File: rtl/mrb_sc_bank.sv
module mrb_sc_bank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] done_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~done_i) | set_i;
  end

  assign q_o = q;

  a_r12_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  a_r12_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_o & done_i & ~set_i) != '0) |=> ((q_o & $past(q_o & done_i & ~set_i)) == '0));
  a_r12_no_spontaneous_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((q_o & ~$past(q_o)) == '0));
endmodule

// File: rtl/mrb_access_decode.sv
module mrb_access_decode #(
  parameter int                PORT_W    = 5,
  parameter int                DEV_W     = 5,
  parameter logic [PORT_W-1:0] PORT_ADDR = '0,
  parameter int                NDEV      = 4
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [7:0]        addr_hi_i,
  input  logic [7:0]        wdata_hi_i,
  output logic              port_hit_o,
  output logic              wdata_ok_o,
  output logic [NDEV-1:0]   dev_sel_o
);
  logic addr_ok;

  assign port_hit_o = (port_i == PORT_ADDR);
  assign addr_ok    = (addr_hi_i == 8'h00);
  assign wdata_ok_o = (wdata_hi_i == 8'h00);

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign dev_sel_o[d] = addr_ok && (dev_i == DEV_W'(d));
  end
endmodule

// File: rtl/mrb_generic_regs.sv
module mrb_generic_regs
  import mrb_pkg::*;
#(
  parameter int         ALM_W   = 4,
  parameter int         DIV_W   = 5,
  parameter int         CMD_W   = 2,
  parameter logic [7:0] CHIP_ID = 8'h5C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_req_t         req_i,
  input  logic [ALM_W-1:0] alarm_i,
  input  logic [CMD_W-1:0] done_i,
  output logic [7:0]       cfg_o,
  output logic [DIV_W-1:0] div_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [7:0]       rdata_o
);
  logic [7:0]       cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [ALM_W-1:0] alarm_shown;
  logic [CMD_W-1:0] cmd_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else if (req_i.wr) begin
      if (req_i.addr == G_CFG) cfg_q <= req_i.wdata;
      // narrow field: bits above DIV_W are dropped
      if (req_i.addr == G_DIV) div_q <= req_i.wdata[DIV_W-1:0];
    end
  end

  mrb_latch_bank #(.W(ALM_W), .HOLD_HIGH(1'b1)) u_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_i    (alarm_i),
    .release_i (req_i.rd && (req_i.addr == G_ALARM)),
    .shown_o   (alarm_shown)
  );

  assign cmd_set = (req_i.wr && (req_i.addr == G_CMD)) ? req_i.wdata[CMD_W-1:0] : '0;

  mrb_sc_bank #(.W(CMD_W)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (cmd_set),
    .done_i (done_i),
    .q_o    (cmd_o)
  );

  always_comb begin
    unique case (req_i.addr)
      G_CFG:   rdata_o = cfg_q;
      G_ID:    rdata_o = CHIP_ID;
      G_ALARM: rdata_o = 8'(alarm_shown);
      G_DIV:   rdata_o = 8'(div_q);
      G_CMD:   rdata_o = 8'(cmd_o);
      default: rdata_o = 8'h00;
    endcase
  end

  assign cfg_o = cfg_q;
  assign div_o = div_q;

  a_r7_id_constant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.addr == G_ID) |-> (rdata_o == CHIP_ID));
  a_r6_div_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.wr && req_i.addr == G_DIV) |=> (div_o == $past(req_i.wdata[DIV_W-1:0])));
endmodule

// File: rtl/mrb_lane_regs.sv
module mrb_lane_regs
  import mrb_pkg::*;
#(
  parameter int LINK_W = 4,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_req_t          req_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              done_i,
  output logic [7:0]        cfg_o,
  output logic              cmd_o,
  output logic [7:0]        rdata_o
);
  logic [7:0]        cfg_q;
  logic [LINK_W-1:0] link_shown;
  logic [ERR_W-1:0]  err_shown;

  always_ff @(posedge clk) begin
    if (!rst_n)                               cfg_q <= '0;
    else if (req_i.wr && req_i.addr == L_CFG) cfg_q <= req_i.wdata;
  end

  mrb_latch_bank #(.W(LINK_W), .HOLD_HIGH(1'b0)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_i    (link_i),
    .release_i (req_i.rd && (req_i.addr == L_LINK)),
    .shown_o   (link_shown)
  );

  mrb_latch_bank #(.W(ERR_W), .HOLD_HIGH(1'b1)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_i    (err_i),
    .release_i (req_i.rd && (req_i.addr == L_ERR)),
    .shown_o   (err_shown)
  );

  mrb_sc_bank #(.W(1)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (req_i.wr && (req_i.addr == L_CMD) && req_i.wdata[0]),
    .done_i (done_i),
    .q_o    (cmd_o)
  );

  always_comb begin
    unique case (req_i.addr)
      L_CFG:   rdata_o = cfg_q;
      L_LINK:  rdata_o = 8'(link_shown);
      L_ERR:   rdata_o = 8'(err_shown);
      L_CMD:   rdata_o = 8'(cmd_o);
      default: rdata_o = 8'h00;
    endcase
  end

  assign cfg_o = cfg_q;

  a_r5_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.wr && req_i.addr == L_CFG) |=> (cfg_o == $past(req_i.wdata)));
  a_r13_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i.wr && req_i.addr == L_CFG) |=> $stable(cfg_o));
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import mrb_pkg::*;
#(
  parameter int                PORT_W    = 5,
  parameter int                DEV_W     = 5,
  parameter logic [PORT_W-1:0] PORT_ADDR = '0,
  parameter int                NLANE     = 3,
  parameter int                LINK_W    = 4,
  parameter int                ERR_W     = 4,
  parameter int                ALM_W     = 4,
  parameter int                DIV_W     = 5,
  parameter int                CMD_W     = 2,
  parameter logic [7:0]        CHIP_ID   = 8'h5C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PORT_W-1:0]       acc_port_i,
  input  logic [DEV_W-1:0]        acc_dev_i,
  input  logic [15:0]             acc_addr_i,
  input  logic [15:0]             acc_wdata_i,
  input  logic                    acc_rd_i,
  input  logic                    acc_wr_i,
  output logic                    rd_valid_o,
  output logic [15:0]             rd_data_o,
  input  logic [ALM_W-1:0]        gen_alarm_i,
  input  logic [CMD_W-1:0]        gen_done_i,
  output logic [7:0]              gen_cfg_o,
  output logic [DIV_W-1:0]        gen_div_o,
  output logic [CMD_W-1:0]        gen_cmd_o,
  input  logic [NLANE*LINK_W-1:0] lane_link_i,
  input  logic [NLANE*ERR_W-1:0]  lane_err_i,
  input  logic [NLANE-1:0]        lane_done_i,
  output logic [NLANE*8-1:0]      lane_cfg_o,
  output logic [NLANE-1:0]        lane_cmd_o
);
  localparam int NDEV = NLANE + 1;

  logic            port_hit;
  logic            wdata_ok;
  logic [NDEV-1:0] dev_sel;
  reg_req_t        req   [NDEV];
  logic [7:0]      rdata [NDEV];
  logic [7:0]      sel_data;
  logic            rd_valid_q;
  logic [15:0]     rd_data_q;

  mrb_access_decode #(
    .PORT_W(PORT_W), .DEV_W(DEV_W), .PORT_ADDR(PORT_ADDR), .NDEV(NDEV)
  ) u_dec (
    .port_i     (acc_port_i),
    .dev_i      (acc_dev_i),
    .addr_hi_i  (acc_addr_i[15:8]),
    .wdata_hi_i (acc_wdata_i[15:8]),
    .port_hit_o (port_hit),
    .wdata_ok_o (wdata_ok),
    .dev_sel_o  (dev_sel)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_req
    assign req[d] = '{wr:    acc_wr_i && port_hit && dev_sel[d] && wdata_ok,
                      rd:    acc_rd_i && port_hit && dev_sel[d],
                      addr:  acc_addr_i[7:0],
                      wdata: acc_wdata_i[7:0]};
  end

  mrb_generic_regs #(
    .ALM_W(ALM_W), .DIV_W(DIV_W), .CMD_W(CMD_W), .CHIP_ID(CHIP_ID)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req[0]),
    .alarm_i (gen_alarm_i),
    .done_i  (gen_done_i),
    .cfg_o   (gen_cfg_o),
    .div_o   (gen_div_o),
    .cmd_o   (gen_cmd_o),
    .rdata_o (rdata[0])
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    mrb_lane_regs #(.LINK_W(LINK_W), .ERR_W(ERR_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req[l+1]),
      .link_i  (lane_link_i[l*LINK_W +: LINK_W]),
      .err_i   (lane_err_i[l*ERR_W +: ERR_W]),
      .done_i  (lane_done_i[l]),
      .cfg_o   (lane_cfg_o[l*8 +: 8]),
      .cmd_o   (lane_cmd_o[l]),
      .rdata_o (rdata[l+1])
    );
  end

  always_comb begin
    sel_data = 8'h00;
    for (int d = 0; d < NDEV; d++) begin
      if (dev_sel[d]) sel_data = sel_data | rdata[d];
    end
  end

  // answer registered; the latch release lands on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= acc_rd_i && port_hit;
      if (acc_rd_i && port_hit) rd_data_q <= {8'h00, sel_data};
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  a_r1_port_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd_i && acc_port_i != PORT_ADDR) |=> !rd_valid_o);
  a_r4_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd_i && acc_port_i == PORT_ADDR) |=> rd_valid_o);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_data_o[15:8] == 8'h00));
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd_i && acc_port_i == PORT_ADDR && acc_addr_i[15:8] != 8'h00) |=> (rd_data_o == 16'h0000));
  a_r2_one_device: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));
endmodule

// File: tb/mgmt_reg_bank_test.sv
module mgmt_reg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  acc_port = '0;
  logic [4:0]  acc_dev = '0;
  logic [15:0] acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [3:0]  gen_alarm = '0;
  logic [1:0]  gen_done = '0;
  logic [7:0]  gen_cfg;
  logic [4:0]  gen_div;
  logic [1:0]  gen_cmd;
  logic [11:0] lane_link = 12'hFFF;
  logic [11:0] lane_err = '0;
  logic [2:0]  lane_done = '0;
  logic [23:0] lane_cfg;
  logic [2:0]  lane_cmd;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  mgmt_reg_bank uut (
    .clk(clk), .rst_n(rst_n),
    .acc_port_i(acc_port), .acc_dev_i(acc_dev), .acc_addr_i(acc_addr),
    .acc_wdata_i(acc_wdata), .acc_rd_i(acc_rd), .acc_wr_i(acc_wr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .gen_alarm_i(gen_alarm), .gen_done_i(gen_done),
    .gen_cfg_o(gen_cfg), .gen_div_o(gen_div), .gen_cmd_o(gen_cmd),
    .lane_link_i(lane_link), .lane_err_i(lane_err), .lane_done_i(lane_done),
    .lane_cfg_o(lane_cfg), .lane_cmd_o(lane_cmd)
  );

  // {op(0 write,1 read,2 read-no-answer), req, port, dev, addr, data, mask}
  localparam int NV = 25;
  localparam logic [63:0] VEC [NV] = '{
    {2'd0, 4'd5,  5'd0, 5'd0, 16'h0000, 16'h0034, 16'h0000}, // R5
    {2'd1, 4'd5,  5'd0, 5'd0, 16'h0000, 16'h0034, 16'hFFFF}, // R5
    {2'd0, 4'd1,  5'd1, 5'd0, 16'h0000, 16'h00FF, 16'h0000}, // R1
    {2'd1, 4'd1,  5'd0, 5'd0, 16'h0000, 16'h0034, 16'hFFFF}, // R1
    {2'd2, 4'd1,  5'd1, 5'd0, 16'h0000, 16'h0000, 16'h0000}, // R1
    {2'd0, 4'd2,  5'd0, 5'd1, 16'h0000, 16'h0011, 16'h0000}, // R2
    {2'd0, 4'd2,  5'd0, 5'd2, 16'h0000, 16'h0022, 16'h0000}, // R2
    {2'd0, 4'd2,  5'd0, 5'd3, 16'h0000, 16'h0033, 16'h0000}, // R2
    {2'd1, 4'd2,  5'd0, 5'd1, 16'h0000, 16'h0011, 16'hFFFF}, // R2
    {2'd1, 4'd2,  5'd0, 5'd2, 16'h0000, 16'h0022, 16'hFFFF}, // R2
    {2'd1, 4'd2,  5'd0, 5'd3, 16'h0000, 16'h0033, 16'hFFFF}, // R2
    {2'd0, 4'd2,  5'd0, 5'd4, 16'h0000, 16'h0044, 16'h0000}, // R2
    {2'd1, 4'd2,  5'd0, 5'd4, 16'h0000, 16'h0000, 16'hFFFF}, // R2
    {2'd1, 4'd2,  5'd0, 5'd0, 16'h0000, 16'h0034, 16'hFFFF}, // R2
    {2'd0, 4'd3,  5'd0, 5'd0, 16'h0100, 16'h0099, 16'h0000}, // R3
    {2'd0, 4'd3,  5'd0, 5'd0, 16'h0000, 16'h1299, 16'h0000}, // R3
    {2'd1, 4'd3,  5'd0, 5'd0, 16'h0000, 16'h0034, 16'hFFFF}, // R3
    {2'd1, 4'd3,  5'd0, 5'd0, 16'h0100, 16'h0000, 16'hFFFF}, // R3
    {2'd0, 4'd6,  5'd0, 5'd0, 16'h0003, 16'h00FF, 16'h0000}, // R6
    {2'd1, 4'd6,  5'd0, 5'd0, 16'h0003, 16'h001F, 16'hFF1F}, // R6
    {2'd1, 4'd7,  5'd0, 5'd0, 16'h0001, 16'h005C, 16'hFFFF}, // R7
    {2'd0, 4'd7,  5'd0, 5'd0, 16'h0001, 16'h0000, 16'h0000}, // R7
    {2'd1, 4'd7,  5'd0, 5'd0, 16'h0001, 16'h005C, 16'hFFFF}, // R7
    {2'd1, 4'd13, 5'd0, 5'd0, 16'h0007, 16'h0000, 16'hFFFF}, // R13
    {2'd1, 4'd13, 5'd0, 5'd1, 16'h0009, 16'h0000, 16'hFFFF}  // R13
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] p, input logic [4:0] d, input logic [15:0] a, input logic [15:0] v);
    @(negedge clk);
    acc_port = p; acc_dev = d; acc_addr = a; acc_wdata = v; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] p, input logic [4:0] d, input logic [15:0] a,
                    output logic vld, output logic [15:0] dat);
    @(negedge clk);
    acc_port = p; acc_dev = d; acc_addr = a; acc_rd = 1'b1;
    @(negedge clk);
    vld = rd_valid; dat = rd_data; acc_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] d, input logic [15:0] a, input logic [15:0] exp);
    logic v;
    logic [15:0] x;
    rd(5'd0, d, a, v, x);
    chk(tag, {15'd0, v}, 32'd1);
    chk(tag, {16'd0, x}, {16'd0, exp});
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic v;
    logic [15:0] x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14: reset state
    chk("R14 valid", {31'd0, rd_valid}, 32'd0);
    chk("R14 cfg", {24'd0, gen_cfg}, 32'd0);
    chk("R14 cmd", {27'd0, lane_cmd, gen_cmd}, 32'd0);
    chk("R14 lane cfg", {8'd0, lane_cfg}, 32'd0);
    rd_chk("R14 link clear", 5'd1, 16'h0001, 16'h000F);
    // R4: valid lasts one cycle
    @(negedge clk);
    chk("R4 single pulse", {31'd0, rd_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("vec %0d R%0d", i, e[61:58]);
      if (e[63:62] == 2'd0) begin
        wr(e[57:53], e[52:48], e[47:32], e[31:16]);
      end else begin
        rd(e[57:53], e[52:48], e[47:32], v, x);
        chk(tag, {31'd0, v}, (e[63:62] == 2'd1) ? 32'd1 : 32'd0);
        if (e[63:62] == 2'd1) chk(tag, {16'd0, x & e[15:0]}, {16'd0, e[31:16] & e[15:0]});
      end
    end

    chk("R5 gen cfg out", {24'd0, gen_cfg}, 32'h34);
    chk("R5 lane cfg out", {8'd0, lane_cfg}, 32'h332211);
    chk("R6 div out", {27'd0, gen_div}, 32'h1F);

    // R8 / R9: lane 2 link bit 3
    @(negedge clk); lane_link[11] = 1'b0;
    @(negedge clk); lane_link[11] = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R8 held low", 5'd3, 16'h0001, 16'h0007);
    rd_chk("R9 follows live", 5'd3, 16'h0001, 16'h000F);

    // R1: foreign port read must not release lane 1 bit 0
    @(negedge clk); lane_link[4] = 1'b0;
    @(negedge clk); lane_link[4] = 1'b1;
    rd(5'd1, 5'd2, 16'h0001, v, x);
    chk("R1 no answer", {31'd0, v}, 32'd0);
    rd_chk("R1 still held", 5'd2, 16'h0001, 16'h000E);
    rd_chk("R9 released", 5'd2, 16'h0001, 16'h000F);

    // R11: event in the same cycle as the releasing read, lane 0 bit 1
    @(negedge clk); lane_link[1] = 1'b0;
    @(negedge clk); lane_link[1] = 1'b1;
    @(negedge clk);
    acc_port = 5'd0; acc_dev = 5'd1; acc_addr = 16'h0001; acc_rd = 1'b1; lane_link[1] = 1'b0;
    @(negedge clk);
    chk("R11 read shows event", {16'd0, rd_data}, 32'h000D);
    acc_rd = 1'b0; lane_link[1] = 1'b1;
    rd_chk("R11 event won", 5'd1, 16'h0001, 16'h000D);
    rd_chk("R11 then live", 5'd1, 16'h0001, 16'h000F);

    // R10: latching-high on lane error and chip alarm
    @(negedge clk); lane_err[2] = 1'b1;
    @(negedge clk); lane_err[2] = 1'b0;
    rd_chk("R10 lane err held", 5'd1, 16'h0002, 16'h0004);
    rd_chk("R10 lane err cleared", 5'd1, 16'h0002, 16'h0000);
    @(negedge clk); gen_alarm[0] = 1'b1;
    @(negedge clk); gen_alarm[0] = 1'b0;
    rd_chk("R10 alarm held", 5'd0, 16'h0002, 16'h0001);
    rd_chk("R10 alarm cleared", 5'd0, 16'h0002, 16'h0000);

    // R13: writes to latching registers do nothing
    wr(5'd0, 5'd1, 16'h0002, 16'h00FF);
    rd_chk("R13 err write ignored", 5'd1, 16'h0002, 16'h0000);
    wr(5'd0, 5'd1, 16'h0001, 16'h0000);
    rd_chk("R13 link write ignored", 5'd1, 16'h0001, 16'h000F);

    // R12: self-clearing commands
    wr(5'd0, 5'd0, 16'h0004, 16'h0003);
    chk("R12 gen set", {30'd0, gen_cmd}, 32'h3);
    rd_chk("R12 gen read", 5'd0, 16'h0004, 16'h0003);
    @(negedge clk); gen_done = 2'b01;
    @(negedge clk); gen_done = 2'b00;
    chk("R12 gen bit0 done", {30'd0, gen_cmd}, 32'h2);
    wr(5'd0, 5'd0, 16'h0004, 16'h0000);
    chk("R12 write 0 ignored", {30'd0, gen_cmd}, 32'h2);
    rd_chk("R12 gen read after done", 5'd0, 16'h0004, 16'h0002);
    @(negedge clk); gen_done = 2'b10;
    @(negedge clk); gen_done = 2'b00;
    chk("R12 gen bit1 done", {30'd0, gen_cmd}, 32'h0);
    wr(5'd0, 5'd3, 16'h0003, 16'h0001);
    chk("R12 lane2 set", {29'd0, lane_cmd}, 32'h4);
    repeat (3) @(negedge clk);
    chk("R12 lane2 holds", {29'd0, lane_cmd}, 32'h4);
    @(negedge clk); lane_done = 3'b100;
    @(negedge clk); lane_done = 3'b000;
    chk("R12 lane2 done", {29'd0, lane_cmd}, 32'h0);
    rd_chk("R12 lane2 read", 5'd3, 16'h0003, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule